// File: doc/BRIEF.md
# Power-Management Event and Control Register Block

This block holds the fixed power-management event registers that system software uses for timer events, power-button handling and sleep entry. It sits on a simple word-addressed register bus with a write strobe and a combinational read path. It contains four registers:

- a 16-bit event status register whose bits are cleared by writing 1;
- a 16-bit event enable register;
- a 16-bit control register;
- a free-running power-management timer, `TMR_W` bits wide (24 by default).

The timer advances once per cycle of `tick_en`. Each time the count reaches an armed half-range boundary, the block raises a timer event flag. A level-sensitive system control interrupt (`sci`) is high while any enabled event of the interrupt class is pending.

A control write with the sleep-enable bit set is decoded at once and never stored. Sleep type 0 gives a one-cycle shutdown request. Sleep type 1 marks wake and power-button status, then gives a one-cycle reset request together with a one-cycle suspend-to-RAM indication.

A separate power-management command port turns interrupt routing on or off, and can raise a one-cycle system-management pulse. A power-button event input is latched into status only while its enable bit is set.

Top module: `pm_event_regs`

## Requirements
- R1: Only `bus_addr[5:0]` is decoded. The byte offsets are 0x00 status, 0x02 enable, 0x04 control and 0x08 timer. A read returns the register zero-extended to 32 bits. Any other offset reads 0, and a write to it changes nothing (the timer offset is read-only).
- R2: After reset, status, enable, control and the timer all read 0, every pulse output is low and `sci` is low. The first armed timer boundary is 2^(TMR_W-1).
- R3: The timer increments by one on each clock edge where `tick_en` is 1, and holds otherwise. A read at offset 0x08 returns the count in bits TMR_W-1:0.
- R4: Status bit 0 (timer event) is set in the cycle after the count equals the armed boundary. It is not set before that count is reached.
- R5: Writing 1 to a status bit clears it, and writing 0 leaves it. A hardware set in the same cycle as a clear of the same bit wins.
- R6: The enable register reads back what was written. `sci` is 1 exactly when status AND enable is nonzero in bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (real-time clock). Bit 15 (wake) does not drive `sci`.
- R7: A control write stores every bit except bit 13 (sleep enable), which always reads 0. When bit 13 is written as 1, sleep type bits 12:10 are decoded. Type 0 raises `shutdown_req` for exactly one cycle, in the cycle after the write.
- R8: Sleep type 1 sets status bits 15 and 8, and raises `reset_req` and `s3_pulse` for one cycle after the write. Every other sleep type causes no pulse and no status change.
- R9: A command of 0xF1 sets control bit 0 (interrupt routing enable), and 0xF0 clears it. Other command values leave control unchanged. Every command write raises `smi_pulse` for one cycle when `smi_cfg_en` is 1, and not when it is 0.
- R10: A `pwrbtn_evt` pulse sets status bit 8 only while enable bit 8 is 1. Otherwise it has no effect.
- R11: When software writes 1 to status bit 0 while it is set, the timer re-arms. The next boundary is the next multiple of 2^(TMR_W-1) above the current count, wrapping to 0 past the top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset; low 6 bits decoded |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| tick_en | input | 1 | Timer advance enable |
| pwrbtn_evt | input | 1 | Power-button event |
| apm_wr | input | 1 | Command port write strobe |
| apm_cmd | input | 8 | Command value |
| smi_cfg_en | input | 1 | Enables the system-management pulse |
| sci | output | 1 | Level system control interrupt |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle reset request |
| s3_pulse | output | 1 | One-cycle suspend-to-RAM indication |
| smi_pulse | output | 1 | One-cycle system-management pulse |

## Verification
The timer event path is driven to a count one below the boundary and then onto it. This separates an early or off-by-one compare from a correct one. After a clear that re-arms the timer, the count is stepped across the top of its range, which shows whether the new boundary wraps to zero or sits at a stale value. Sleep entry is tried with types 0, 1 and 3, which distinguishes shutdown, reset with status marking and a no-op. Power-button events arrive with the enable clear, with it set, and in the same cycle as a software clear, which tells gating and set-over-clear priority apart.

// File: rtl/pm_event_pkg.sv
package pm_event_pkg;

    localparam int REG_W = 16;

    // register byte offsets within the 64-byte window
    localparam logic [5:0] OFS_STS = 6'h00;
    localparam logic [5:0] OFS_EN  = 6'h02;
    localparam logic [5:0] OFS_CTL = 6'h04;
    localparam logic [5:0] OFS_TMR = 6'h08;

    // status / enable bit positions (shared)
    localparam int B_TMR    = 0;
    localparam int B_GLOCK  = 5;
    localparam int B_PWRBTN = 8;
    localparam int B_RTC    = 10;
    localparam int B_WAKE   = 15;

    // control bit positions
    localparam int B_ROUTE   = 0;
    localparam int B_SLEEP   = 13;
    localparam int SLPTYP_LO = 10;

    localparam logic [REG_W-1:0] SCI_MASK =
        REG_W'((1 << B_TMR) | (1 << B_GLOCK) | (1 << B_PWRBTN) | (1 << B_RTC));

    localparam logic [7:0] CMD_ROUTE_ON  = 8'hF1;
    localparam logic [7:0] CMD_ROUTE_OFF = 8'hF0;

    typedef enum logic [1:0] {
        SLP_NONE = 2'd0,
        SLP_OFF  = 2'd1,
        SLP_S3   = 2'd2
    } slp_act_e;

    typedef struct packed {
        logic [REG_W-1:0] sts;
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] ctl;
        logic             shut;
        logic             rst;
        logic             s3;
        logic             smi;
    } pm_state_t;

endpackage

// File: rtl/pm_half_wrap_timer.sv
module pm_half_wrap_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             rearm,
    output logic [TMR_W-1:0] count,
    output logic             hit
);
    localparam logic [TMR_W-1:0] HALF = {1'b1, {(TMR_W-1){1'b0}}};

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic [TMR_W-1:0] ovf;
        logic             armed;
    } tmr_state_t;

    tmr_state_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        hit = t_q.armed && (t_q.cnt == t_q.ovf);
        if (hit) begin
            t_d.armed = 1'b0;
        end
        if (tick_en) begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
        if (rearm) begin
            // next multiple of the half range above the current count
            t_d.ovf   = {~t_q.cnt[TMR_W-1], {(TMR_W-1){1'b0}}};
            t_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.cnt   <= '0;
            t_q.ovf   <= HALF;
            t_q.armed <= 1'b1;
        end else begin
            t_q <= t_d;
        end
    end

    assign count = t_q.cnt;

endmodule

// File: rtl/pm_sleep_decode.sv
module pm_sleep_decode
    import pm_event_pkg::*;
(
    input  logic             ctl_wr,
    input  logic [REG_W-1:0] ctl_val,
    output slp_act_e         act
);
    logic [2:0] slp_type;

    always_comb begin
        slp_type = ctl_val[SLPTYP_LO +: 3];
        act      = SLP_NONE;
        if (ctl_wr && ctl_val[B_SLEEP]) begin
            case (slp_type)
                3'd0:    act = SLP_OFF;
                3'd1:    act = SLP_S3;
                default: act = SLP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/pm_read_mux.sv
module pm_read_mux
    import pm_event_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TMR_W  = 24
) (
    input  logic [5:0]        offset,
    input  logic [REG_W-1:0]  sts,
    input  logic [REG_W-1:0]  en,
    input  logic [REG_W-1:0]  ctl,
    input  logic [TMR_W-1:0]  cnt,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (offset)
            OFS_STS: rdata[REG_W-1:0] = sts;
            OFS_EN:  rdata[REG_W-1:0] = en;
            OFS_CTL: rdata[REG_W-1:0] = ctl;
            OFS_TMR: rdata[TMR_W-1:0] = cnt;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/pm_event_regs.sv
module pm_event_regs
    import pm_event_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int TMR_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_en,
    input  logic              pwrbtn_evt,
    input  logic              apm_wr,
    input  logic [7:0]        apm_cmd,
    input  logic              smi_cfg_en,
    output logic              sci,
    output logic              shutdown_req,
    output logic              reset_req,
    output logic              s3_pulse,
    output logic              smi_pulse
);
    logic [5:0]       offset;
    logic [REG_W-1:0] wval;
    logic             wr_sts, wr_en, wr_ctl;
    logic             tmr_rearm, tmr_hit;
    logic [TMR_W-1:0] tmr_cnt;
    slp_act_e         slp_act;
    logic [REG_W-1:0] hw_set;
    logic [REG_W-1:0] sts_q, en_q, ctl_q;
    logic             unused_addr_hi, unused_wdata_hi;

    pm_state_t s_q, s_d;

    assign offset          = bus_addr[5:0];
    assign wval            = bus_wdata[REG_W-1:0];
    assign unused_addr_hi  = ^bus_addr[ADDR_W-1:6];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:REG_W];

    assign wr_sts = bus_wr && (offset == OFS_STS);
    assign wr_en  = bus_wr && (offset == OFS_EN);
    assign wr_ctl = bus_wr && (offset == OFS_CTL);

    assign sts_q = s_q.sts;
    assign en_q  = s_q.en;
    assign ctl_q = s_q.ctl;

    // re-arm only when a set timer flag is being acknowledged
    assign tmr_rearm = wr_sts && wval[B_TMR] && s_q.sts[B_TMR];

    pm_half_wrap_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .rearm   (tmr_rearm),
        .count   (tmr_cnt),
        .hit     (tmr_hit)
    );

    pm_sleep_decode u_sleep (
        .ctl_wr  (wr_ctl),
        .ctl_val (wval),
        .act     (slp_act)
    );

    pm_read_mux #(.DATA_W(DATA_W), .TMR_W(TMR_W)) u_rmux (
        .offset (offset),
        .sts    (sts_q),
        .en     (en_q),
        .ctl    (ctl_q),
        .cnt    (tmr_cnt),
        .rdata  (bus_rdata)
    );

    always_comb begin
        s_d      = s_q;
        s_d.shut = 1'b0;
        s_d.rst  = 1'b0;
        s_d.s3   = 1'b0;
        s_d.smi  = 1'b0;

        // hardware event sources
        hw_set = '0;
        if (tmr_hit) begin
            hw_set[B_TMR] = 1'b1;
        end
        if (pwrbtn_evt && s_q.en[B_PWRBTN]) begin
            hw_set[B_PWRBTN] = 1'b1;
        end
        if (slp_act == SLP_S3) begin
            hw_set[B_WAKE]   = 1'b1;
            hw_set[B_PWRBTN] = 1'b1;
        end

        // status: software clear first, hardware set overrides
        if (wr_sts) begin
            s_d.sts = s_q.sts & ~wval;
        end
        s_d.sts = s_d.sts | hw_set;

        if (wr_en) begin
            s_d.en = wval;
        end

        if (wr_ctl) begin
            s_d.ctl          = wval;
            s_d.ctl[B_SLEEP] = 1'b0;
        end

        if (apm_wr) begin
            if (apm_cmd == CMD_ROUTE_ON) begin
                s_d.ctl[B_ROUTE] = 1'b1;
            end else if (apm_cmd == CMD_ROUTE_OFF) begin
                s_d.ctl[B_ROUTE] = 1'b0;
            end
            s_d.smi = smi_cfg_en;
        end

        s_d.shut = (slp_act == SLP_OFF);
        s_d.rst  = (slp_act == SLP_S3);
        s_d.s3   = (slp_act == SLP_S3);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sci          = |(s_q.sts & s_q.en & SCI_MASK);
    assign shutdown_req = s_q.shut;
    assign reset_req    = s_q.rst;
    assign s3_pulse     = s_q.s3;
    assign smi_pulse    = s_q.smi;

endmodule

// File: rtl/pm_event_regs_chk.sv
module pm_event_regs_chk
    import pm_event_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [5:0]        offset,
    input logic [REG_W-1:0]  wval,
    input logic [DATA_W-1:0] rdata,
    input logic              apm_wr,
    input logic              smi_cfg_en,
    input logic              tmr_hit,
    input logic [REG_W-1:0]  sts,
    input logic [REG_W-1:0]  en,
    input logic [REG_W-1:0]  ctl,
    input logic              sci,
    input logic              shut,
    input logic              rst,
    input logic              s3,
    input logic              smi
);
    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (offset != OFS_STS && offset != OFS_EN && offset != OFS_CTL && offset != OFS_TMR)
        |-> (rdata == '0));

    p_tmr_flag_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[B_TMR]) |-> $past(tmr_hit));

    p_sci_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sci |-> |(en & SCI_MASK));

    p_sleep_bit_unheld_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[B_SLEEP]);

    p_shutdown_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shut |-> $past(bus_wr && offset == OFS_CTL && wval[B_SLEEP]
                       && wval[SLPTYP_LO +: 3] == 3'd0));

    p_s3_marks_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst |-> (s3 && sts[B_WAKE] && sts[B_PWRBTN]));

    p_s3_pairs_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s3 |-> rst);

    p_smi_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smi |-> $past(apm_wr && smi_cfg_en));

endmodule

bind pm_event_regs pm_event_regs_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .offset     (offset),
    .wval       (wval),
    .rdata      (bus_rdata),
    .apm_wr     (apm_wr),
    .smi_cfg_en (smi_cfg_en),
    .tmr_hit    (tmr_hit),
    .sts        (sts_q),
    .en         (en_q),
    .ctl        (ctl_q),
    .sci        (sci),
    .shut       (shutdown_req),
    .rst        (reset_req),
    .s3         (s3_pulse),
    .smi        (smi_pulse)
);

// File: tb/tb_pm_event_regs.sv
module tb_pm_event_regs;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int TMR_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              tick_en = 1'b0;
    logic              pwrbtn_evt = 1'b0;
    logic              apm_wr = 1'b0;
    logic [7:0]        apm_cmd = '0;
    logic              smi_cfg_en = 1'b0;
    logic              sci, shutdown_req, reset_req, s3_pulse, smi_pulse;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_event_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMR_W(TMR_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .pwrbtn_evt(pwrbtn_evt), .apm_wr(apm_wr), .apm_cmd(apm_cmd),
        .smi_cfg_en(smi_cfg_en), .sci(sci), .shutdown_req(shutdown_req),
        .reset_req(reset_req), .s3_pulse(s3_pulse), .smi_pulse(smi_pulse)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h0002, 32'h0000_FFFF, 32'h0,         8'd6}, // R6 enable write
        '{1'b0, 16'h0002, 32'h0,         32'h0000_FFFF, 8'd6}, // R6 enable readback
        '{1'b1, 16'h0004, 32'h0000_2301, 32'h0,         8'd7}, // R7 control with sleep bit
        '{1'b0, 16'h0004, 32'h0,         32'h0000_0301, 8'd7}, // R7 sleep bit not held
        '{1'b0, 16'h0006, 32'h0,         32'h0,         8'd1}, // R1 unmapped read
        '{1'b1, 16'h0006, 32'h0000_0000, 32'h0,         8'd1}, // R1 unmapped write
        '{1'b0, 16'h0002, 32'h0,         32'h0000_FFFF, 8'd1}, // R1 enable untouched
        '{1'b0, 16'h0044, 32'h0,         32'h0000_0301, 8'd1}, // R1 alias of control
        '{1'b1, 16'h000C, 32'h0000_1234, 32'h0,         8'd1}, // R1 unmapped write
        '{1'b0, 16'h000C, 32'h0,         32'h0,         8'd1}, // R1 unmapped read
        '{1'b1, 16'h0008, 32'h0000_0055, 32'h0,         8'd1}, // R1 timer read-only
        '{1'b0, 16'h0008, 32'h0,         32'h0,         8'd1}, // R1 timer unchanged
        '{1'b1, 16'h0002, 32'h0000_0000, 32'h0,         8'd6}, // R6 enable clear
        '{1'b1, 16'h0004, 32'h0000_0000, 32'h0,         8'd7}, // R7 control clear
        '{1'b0, 16'h0004, 32'h0,         32'h0,         8'd7}  // R7 control readback
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] c);
        @(negedge clk);
        apm_wr = 1'b1; apm_cmd = c;
        @(posedge clk);
        @(negedge clk);
        apm_wr = 1'b0;
    endtask

    task automatic button();
        @(negedge clk);
        pwrbtn_evt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pwrbtn_evt = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        bus_read(16'h0000, rd); check("R2 status", rd, 32'h0);
        bus_read(16'h0002, rd); check("R2 enable", rd, 32'h0);
        bus_read(16'h0004, rd); check("R2 control", rd, 32'h0);
        bus_read(16'h0008, rd); check("R2 timer", rd, 32'h0);
        check("R2 outputs", {27'd0, sci, shutdown_req, reset_req, s3_pulse, smi_pulse}, 32'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                bus_write(VECS[i].addr, VECS[i].data);
            end else begin
                bus_read(VECS[i].addr, rd);
                check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
            end
        end

        // R3 timer counting
        tick(5);
        bus_read(16'h0008, rd); check("R3 timer count", rd, 32'h5);

        // R4 first boundary at half range (R2)
        bus_write(16'h0002, 32'h0001);
        tick(8'h7A); idle();
        bus_read(16'h0000, rd); check("R4 not set below boundary", rd, 32'h0);
        tick(1); idle();
        bus_read(16'h0000, rd); check("R4 set at boundary", rd, 32'h1);
        check("R6 sci from timer", {31'd0, sci}, 32'h1);

        // R11 re-arm on clear, next boundary wraps to zero
        tick(8'h10);
        bus_write(16'h0000, 32'h0001);
        bus_read(16'h0000, rd); check("R5 clear timer flag", rd, 32'h0);
        check("R6 sci low after clear", {31'd0, sci}, 32'h0);
        bus_read(16'h0008, rd); check("R3 timer at 0x90", rd, 32'h90);
        tick(8'h6F); idle();
        bus_read(16'h0000, rd); check("R11 not set at top", rd, 32'h0);
        tick(1); idle();
        bus_read(16'h0000, rd); check("R11 set at wrap", rd, 32'h1);
        bus_write(16'h0000, 32'h0001);
        bus_write(16'h0002, 32'h0000);

        // R10 power button gating
        button();
        bus_read(16'h0000, rd); check("R10 ignored when disabled", rd, 32'h0);
        bus_write(16'h0002, 32'h0100);
        button();
        bus_read(16'h0000, rd); check("R10 latched when enabled", rd, 32'h0100);
        check("R6 sci from button", {31'd0, sci}, 32'h1);

        // R5 hardware set wins over clear
        @(negedge clk);
        pwrbtn_evt = 1'b1; bus_wr = 1'b1; bus_addr = 16'h0000; bus_wdata = 32'h0100;
        @(posedge clk);
        @(negedge clk);
        pwrbtn_evt = 1'b0; bus_wr = 1'b0;
        bus_read(16'h0000, rd); check("R5 set beats clear", rd, 32'h0100);
        bus_write(16'h0000, 32'h0100);
        bus_read(16'h0000, rd); check("R5 clear alone", rd, 32'h0);
        bus_write(16'h0002, 32'h0000);

        // R7 sleep type 0
        bus_write(16'h0004, 32'h2000);
        check("R7 shutdown pulse", {30'd0, shutdown_req, reset_req}, 32'h2);
        idle();
        check("R7 shutdown one cycle", {31'd0, shutdown_req}, 32'h0);

        // R8 sleep type 1
        bus_write(16'h0004, 32'h2401);
        check("R8 reset and s3 pulse", {29'd0, shutdown_req, reset_req, s3_pulse}, 32'h3);
        idle();
        check("R8 pulses one cycle", {30'd0, reset_req, s3_pulse}, 32'h0);
        bus_read(16'h0000, rd); check("R8 wake and button status", rd, 32'h8100);
        bus_read(16'h0004, rd); check("R7 control stored", rd, 32'h0401);
        bus_write(16'h0002, 32'h8000);
        check("R6 wake does not drive sci", {31'd0, sci}, 32'h0);
        bus_write(16'h0002, 32'h0100);
        check("R6 sci with button enable", {31'd0, sci}, 32'h1);
        bus_write(16'h0000, 32'hFFFF);
        bus_write(16'h0002, 32'h0000);

        // R8 other sleep type
        bus_write(16'h0004, 32'h2C00);
        check("R8 type 3 no pulse", {29'd0, shutdown_req, reset_req, s3_pulse}, 32'h0);
        bus_read(16'h0000, rd); check("R8 type 3 no status", rd, 32'h0);

        // R9 command port
        smi_cfg_en = 1'b1;
        cmd(8'hF1);
        check("R9 smi pulse", {31'd0, smi_pulse}, 32'h1);
        bus_read(16'h0004, rd); check("R9 route on", rd, 32'h0C01);
        cmd(8'hF0);
        bus_read(16'h0004, rd); check("R9 route off", rd, 32'h0C00);
        smi_cfg_en = 1'b0;
        cmd(8'hF1);
        check("R9 no smi when disabled", {31'd0, smi_pulse}, 32'h0);
        cmd(8'h33);
        bus_read(16'h0004, rd); check("R9 other command no change", rd, 32'h0C01);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule